// File: doc/BRIEF.md
# Flat-Panel Pixel Serializer with Dual Channel

This block turns parallel pixels into serial bit streams for a flat-panel link. On each frame it takes one pixel per channel: red, green and blue colour bits, plus the three timing bits (horizontal sync, vertical sync and data enable). It packs them into 7-bit lane frames and shifts them out on four data lanes per channel. Beside the data lanes, a clock lane sends a fixed pattern that marks where each frame starts and ends.

The block runs on a fast bit clock. An external bit-rate enable, `bit_ce`, is high seven times per pixel period. Each enabled cycle moves every lane to its next bit slot. The pixel, the colour-depth mode and the channel mode are sampled only on the enabled cycle that opens a frame. In 24-bit mode, all four lanes of a channel carry data. In 18-bit mode, the two low bits of each colour component are dropped and only three lanes carry data. In dual-channel mode, channel A carries the even (first) pixel of each pair and channel B carries the odd (second) pixel. Both channels share the same slots and the same timing bits. In single-channel mode, channel B stays silent.

Top module: `panel_serializer`

## Requirements
- R1: While `rst` is high and after it falls, until the first enabled cycle, every data lane and clock-lane output is 0 and the slot position is the first slot.
- R2: Outputs change only on rising clock edges where `bit_ce` is high. Each such edge moves every lane one bit slot forward, and seven slots make one frame.
- R3: Pixel, sync, `depth24` and `dual_mode` inputs are sampled only on the enabled edge that opens a frame (slot 0). Values present on any other edge have no effect on the outputs.
- R4: With `depth24`=1, the 28-bit frame word is {R[7:0], G[7:0], B[7:0], hsync, vsync, de, 0}, where a pixel is {R,G,B} with R in bits 23:16. Lane k (k=0..3) sends word bits [27-7k : 21-7k], most significant bit first, so slot s carries word bit 27-7k-s.
- R5: In 24-bit mode, the last slot (slot 6) of lane 3 is a spare slot and is always 0.
- R6: With `depth24`=0, the frame word is {R[7:2], G[7:2], B[7:2], hsync, vsync, de, 7'b0}. Lanes 0 to 2 send it by the R4 rule, and lane 3 stays 0 for the whole frame.
- R7: An active channel's clock lane sends 1100011 in every frame, most significant bit first, in step with its data lanes.
- R8: With `dual_mode`=0 at frame start, channel B's data lanes and clock lane are 0 for that frame.
- R9: With `dual_mode`=1 at frame start, channel A serializes `pix_even` and channel B serializes `pix_odd`. Both use the same sync bits, depth mode and slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_ce | input | 1 | Bit-slot enable, seven times per pixel period |
| depth24 | input | 1 | 1 = 24-bit colour on four lanes, 0 = 18-bit colour on three lanes |
| dual_mode | input | 1 | 1 = two pixels per frame on both channels |
| pix_even | input | 24 | Even pixel {R,G,B}, sent on channel A |
| pix_odd | input | 24 | Odd pixel {R,G,B}, sent on channel B in dual mode |
| hsync | input | 1 | Horizontal sync timing bit |
| vsync | input | 1 | Vertical sync timing bit |
| de | input | 1 | Data-enable timing bit |
| lane_a | output | 4 | Channel A serial data lanes, lane k on bit k |
| lane_b | output | 4 | Channel B serial data lanes, lane k on bit k |
| lane_clk_a | output | 1 | Channel A clock-lane pattern |
| lane_clk_b | output | 1 | Channel B clock-lane pattern |

## Verification
The assertions assume that `bit_ce` is the only thing that sets frame timing, and that `rst` puts the slot count back to zero. This lets the checker count slots with its own counter. The assertions also take `depth24` and `dual_mode` to matter only at the opening slot, so they record both modes there.

The stimulus raises `bit_ce` with gaps of zero to three idle cycles. Between frame openings it drives random values on every data and mode input, so any sampling at the wrong slot shows up in the output frames. It keeps `bit_ce` low while in reset.

// File: rtl/panel_ser_pkg.sv
package panel_ser_pkg;

    localparam int FRAME_LEN  = 7;
    localparam int LANES      = 4;
    localparam int COMP_W     = 8;
    localparam int KEEP_18    = 6;
    localparam int PIX_W      = 3 * COMP_W;
    localparam int WORD_W     = LANES * FRAME_LEN;
    localparam int SLOT_W     = $clog2(FRAME_LEN);
    localparam logic [FRAME_LEN-1:0] CLK_PATTERN = 7'b1100011;

    typedef logic [FRAME_LEN-1:0] lane_frame_t;
    typedef logic [WORD_W-1:0]    frame_word_t;

    typedef enum logic {
        DEPTH_18 = 1'b0,
        DEPTH_24 = 1'b1
    } depth_e;

    typedef struct packed {
        logic [COMP_W-1:0] r;
        logic [COMP_W-1:0] g;
        logic [COMP_W-1:0] b;
    } rgb_t;

    typedef struct packed {
        logic hs;
        logic vs;
        logic de;
    } sync_t;

    function automatic frame_word_t pack_frame(rgb_t px, sync_t s, depth_e d);
        frame_word_t w;
        if (d == DEPTH_24) begin
            w = {px.r, px.g, px.b, s.hs, s.vs, s.de, 1'b0};
        end else begin
            w = {px.r[COMP_W-1 -: KEEP_18], px.g[COMP_W-1 -: KEEP_18],
                 px.b[COMP_W-1 -: KEEP_18], s.hs, s.vs, s.de,
                 {(WORD_W - 3*KEEP_18 - 3){1'b0}}};
        end
        return w;
    endfunction

    function automatic lane_frame_t lane_slice(frame_word_t w, int k);
        return w[(LANES-1-k)*FRAME_LEN +: FRAME_LEN];
    endfunction

endpackage

// File: rtl/ser_slot_ctr.sv
module ser_slot_ctr #(
    parameter int SLOTS  = 7,
    localparam int CNT_W = $clog2(SLOTS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ce,
    output logic [CNT_W-1:0] slot,
    output logic             first
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(SLOTS - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            slot <= '0;
        end else if (ce) begin
            slot <= (slot == LAST) ? '0 : slot + 1'b1;
        end
    end

    assign first = (slot == '0);
endmodule

// File: rtl/ser_lane_shift.sv
module ser_lane_shift #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ce,
    input  logic         load,
    input  logic [W-1:0] din,
    output logic         q
);
    logic [W-1:0] sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh <= '0;
            q  <= 1'b0;
        end else if (ce) begin
            if (load) begin
                q  <= din[W-1];
                sh <= {din[W-2:0], 1'b0};
            end else begin
                q  <= sh[W-1];
                sh <= {sh[W-2:0], 1'b0};
            end
        end
    end
endmodule

// File: rtl/ser_channel.sv
module ser_channel
    import panel_ser_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             ce,
    input  logic             first,
    input  logic             en,
    input  rgb_t             px,
    input  sync_t            sync_in,
    input  depth_e           depth,
    output logic [LANES-1:0] lanes,
    output logic             clk_lane
);
    frame_word_t word;
    lane_frame_t clk_frame;

    always_comb begin
        word      = en ? pack_frame(px, sync_in, depth) : '0;
        clk_frame = en ? CLK_PATTERN : '0;
    end

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        ser_lane_shift #(.W(FRAME_LEN)) u_shift (
            .clk  (clk),
            .rst  (rst),
            .ce   (ce),
            .load (first),
            .din  (lane_slice(word, k)),
            .q    (lanes[k])
        );
    end

    ser_lane_shift #(.W(FRAME_LEN)) u_clk_shift (
        .clk  (clk),
        .rst  (rst),
        .ce   (ce),
        .load (first),
        .din  (clk_frame),
        .q    (clk_lane)
    );
endmodule

// File: rtl/panel_serializer.sv
module panel_serializer
    import panel_ser_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             bit_ce,
    input  logic             depth24,
    input  logic             dual_mode,
    input  logic [PIX_W-1:0] pix_even,
    input  logic [PIX_W-1:0] pix_odd,
    input  logic             hsync,
    input  logic             vsync,
    input  logic             de,
    output logic [LANES-1:0] lane_a,
    output logic [LANES-1:0] lane_b,
    output logic             lane_clk_a,
    output logic             lane_clk_b
);
    logic [SLOT_W-1:0] slot;
    logic              first;
    sync_t             sync_bits;
    depth_e            depth;

    assign sync_bits = '{hs: hsync, vs: vsync, de: de};
    assign depth     = depth_e'(depth24);

    ser_slot_ctr #(.SLOTS(FRAME_LEN)) u_slots (
        .clk   (clk),
        .rst   (rst),
        .ce    (bit_ce),
        .slot  (slot),
        .first (first)
    );

    ser_channel u_chan_a (
        .clk      (clk),
        .rst      (rst),
        .ce       (bit_ce),
        .first    (first),
        .en       (1'b1),
        .px       (rgb_t'(pix_even)),
        .sync_in  (sync_bits),
        .depth    (depth),
        .lanes    (lane_a),
        .clk_lane (lane_clk_a)
    );

    ser_channel u_chan_b (
        .clk      (clk),
        .rst      (rst),
        .ce       (bit_ce),
        .first    (first),
        .en       (dual_mode),
        .px       (rgb_t'(pix_odd)),
        .sync_in  (sync_bits),
        .depth    (depth),
        .lanes    (lane_b),
        .clk_lane (lane_clk_b)
    );
endmodule

// File: rtl/panel_serializer_chk.sv
module panel_serializer_chk
    import panel_ser_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             bit_ce,
    input logic             depth24,
    input logic             dual_mode,
    input logic [LANES-1:0] lane_a,
    input logic [LANES-1:0] lane_b,
    input logic             lane_clk_a,
    input logic             lane_clk_b
);
    logic [SLOT_W-1:0] sc;
    logic [SLOT_W-1:0] oslot;
    logic              seen;
    logic              f_dual;
    logic              f_18;

    always_ff @(posedge clk) begin
        if (rst) begin
            sc     <= '0;
            oslot  <= '0;
            seen   <= 1'b0;
            f_dual <= 1'b0;
            f_18   <= 1'b0;
        end else if (bit_ce) begin
            oslot <= sc;
            seen  <= 1'b1;
            sc    <= (sc == SLOT_W'(FRAME_LEN-1)) ? '0 : sc + 1'b1;
            if (sc == '0) begin
                f_dual <= dual_mode;
                f_18   <= !depth24;
            end
        end
    end

    p_reset_clears_r1: assert property (@(posedge clk)
        rst |=> (lane_a == '0 && lane_b == '0 && !lane_clk_a && !lane_clk_b));

    p_idle_before_first_r1: assert property (@(posedge clk) disable iff (rst)
        !seen |-> (lane_a == '0 && lane_b == '0 && !lane_clk_a && !lane_clk_b));

    p_hold_without_ce_r2: assert property (@(posedge clk) disable iff (rst)
        !bit_ce |=> ($stable(lane_a) && $stable(lane_b)
                     && $stable(lane_clk_a) && $stable(lane_clk_b)));

    p_spare_slot_zero_r5: assert property (@(posedge clk) disable iff (rst)
        (seen && oslot == SLOT_W'(FRAME_LEN-1)) |-> (!lane_a[LANES-1] && !lane_b[LANES-1]));

    p_lane3_unused_r6: assert property (@(posedge clk) disable iff (rst)
        (seen && f_18) |-> (!lane_a[LANES-1] && !lane_b[LANES-1]));

    p_clk_pattern_a_r7: assert property (@(posedge clk) disable iff (rst)
        seen |-> (lane_clk_a == CLK_PATTERN[SLOT_W'(FRAME_LEN-1) - oslot]));

    p_clk_pattern_b_r7: assert property (@(posedge clk) disable iff (rst)
        (seen && f_dual) |-> (lane_clk_b == CLK_PATTERN[SLOT_W'(FRAME_LEN-1) - oslot]));

    p_chan_b_silent_r8: assert property (@(posedge clk) disable iff (rst)
        (seen && !f_dual) |-> (lane_b == '0 && !lane_clk_b));
endmodule

bind panel_serializer panel_serializer_chk chk_i (
    .clk        (clk),
    .rst        (rst),
    .bit_ce     (bit_ce),
    .depth24    (depth24),
    .dual_mode  (dual_mode),
    .lane_a     (lane_a),
    .lane_b     (lane_b),
    .lane_clk_a (lane_clk_a),
    .lane_clk_b (lane_clk_b)
);

// File: tb/panel_serializer_tb_top.sv
`timescale 1ns/1ps
module panel_serializer_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bit_ce = 1'b0;
    logic        depth24 = 1'b0;
    logic        dual_mode = 1'b0;
    logic [23:0] pix_even = '0;
    logic [23:0] pix_odd = '0;
    logic        hsync = 1'b0;
    logic        vsync = 1'b0;
    logic        de = 1'b0;
    logic [3:0]  lane_a;
    logic [3:0]  lane_b;
    logic        lane_clk_a;
    logic        lane_clk_b;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;
    bit mon_on   = 0;

    logic [27:0] q_exp_a[$];
    logic [27:0] q_exp_b[$];
    logic [6:0]  q_clk_b[$];
    string       q_tag_a[$];
    string       q_tag_b[$];

    always #2.5 clk = ~clk;

    panel_serializer dut_i (
        .clk(clk), .rst(rst), .bit_ce(bit_ce), .depth24(depth24),
        .dual_mode(dual_mode), .pix_even(pix_even), .pix_odd(pix_odd),
        .hsync(hsync), .vsync(vsync), .de(de),
        .lane_a(lane_a), .lane_b(lane_b),
        .lane_clk_a(lane_clk_a), .lane_clk_b(lane_clk_b)
    );

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Expected frame word, built from the R4 / R6 rules
    function automatic logic [27:0] model_word(logic [23:0] p, logic h, logic v,
                                               logic d, logic m24);
        if (m24) return {p, h, v, d, 1'b0};
        return {p[23:18], p[15:10], p[7:2], h, v, d, 7'b0};
    endfunction

    task automatic scramble();
        pix_even  = 24'($urandom);
        pix_odd   = 24'($urandom);
        hsync     = 1'($urandom);
        vsync     = 1'($urandom);
        de        = 1'($urandom);
        depth24   = 1'($urandom);
        dual_mode = 1'($urandom);
    endtask

    // Driver: one frame, seven enabled slots, garbage off slot 0 (R3)
    task automatic send_frame(logic [23:0] pe, logic [23:0] po, logic h, logic v,
                              logic d, logic m24, logic dm, int gap);
        for (int s = 0; s < 7; s++) begin
            for (int g = 0; g < gap; g++) begin
                @(negedge clk);
                bit_ce = 1'b0;
                scramble();
            end
            @(negedge clk);
            bit_ce = 1'b1;
            if (s == 0) begin
                pix_even = pe; pix_odd = po; hsync = h; vsync = v; de = d;
                depth24 = m24; dual_mode = dm;
                q_exp_a.push_back(model_word(pe, h, v, d, m24));
                q_exp_b.push_back(dm ? model_word(po, h, v, d, m24) : 28'h0);
                q_clk_b.push_back(dm ? 7'b1100011 : 7'b0);
                q_tag_a.push_back(m24 ? "R4 R3" : "R6 R3");
                q_tag_b.push_back(dm ? "R9 R3" : "R8 R3");
            end else begin
                scramble();
            end
        end
    endtask

    // Monitor / scoreboard
    initial begin
        int          ms;
        logic [27:0] got_a, got_b;
        logic [6:0]  ca, cb;
        logic [3:0]  pa, pb;
        logic        pca, pcb;
        ms = 0; got_a = '0; got_b = '0; ca = '0; cb = '0;
        pa = '0; pb = '0; pca = 1'b0; pcb = 1'b0;
        wait (mon_on);
        forever begin
            @(posedge clk);
            #1;
            if (bit_ce) begin
                for (int k = 0; k < 4; k++) begin
                    got_a[27 - 7*k - ms] = lane_a[k];
                    got_b[27 - 7*k - ms] = lane_b[k];
                end
                ca[6 - ms] = lane_clk_a;
                cb[6 - ms] = lane_clk_b;
                if (ms == 6) begin
                    check(!lane_a[3] && !lane_b[3], "R5 spare slot",
                          {lane_a, lane_b}, 32'h0);
                    if (q_exp_a.size() == 0) begin
                        check(1'b0, "R2 unexpected frame", 32'(got_a), 32'h0);
                    end else begin
                        logic [27:0] ea, eb;
                        logic [6:0]  ecb;
                        string       ta, tb;
                        ea = q_exp_a.pop_front(); eb = q_exp_b.pop_front();
                        ecb = q_clk_b.pop_front();
                        ta = q_tag_a.pop_front(); tb = q_tag_b.pop_front();
                        check(got_a == ea, ta, 32'(got_a), 32'(ea));
                        check(got_b == eb, tb, 32'(got_b), 32'(eb));
                        check(ca == 7'b1100011, "R7 clock lane A", 32'(ca), 32'h63);
                        check(cb == ecb, "R7 R8 clock lane B", 32'(cb), 32'(ecb));
                    end
                    ms = 0;
                end else begin
                    ms++;
                end
            end else begin
                check(lane_a == pa && lane_b == pb && lane_clk_a == pca
                      && lane_clk_b == pcb, "R2 hold without enable",
                      {lane_a, lane_b, lane_clk_a, lane_clk_b},
                      {pa, pb, pca, pcb});
            end
            pa = lane_a; pb = lane_b; pca = lane_clk_a; pcb = lane_clk_b;
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++; n_checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        scramble();
        @(negedge clk);
        check({lane_a, lane_b, lane_clk_a, lane_clk_b} == 0, "R1 in reset",
              {lane_a, lane_b, lane_clk_a, lane_clk_b}, 32'h0);
        rst = 1'b0;
        repeat (3) begin
            @(negedge clk);
            check({lane_a, lane_b, lane_clk_a, lane_clk_b} == 0, "R1 after reset",
                  {lane_a, lane_b, lane_clk_a, lane_clk_b}, 32'h0);
        end
        mon_on = 1;
        // 24-bit single channel, distinct patterns
        send_frame(24'hFFFFFF, 24'h0, 1, 1, 1, 1, 0, 0);
        send_frame(24'hA5C3E1, 24'h123456, 1, 0, 1, 1, 0, 0);
        send_frame(24'h000000, 24'hFFFFFF, 0, 0, 0, 1, 0, 1);
        // 18-bit single channel
        send_frame(24'hFFFFFF, 24'h0, 1, 1, 1, 0, 0, 0);
        send_frame(24'h5A3C81, 24'h0, 0, 1, 0, 0, 0, 2);
        // dual channel, both depths
        send_frame(24'h112233, 24'hDDEEFF, 1, 0, 1, 1, 1, 0);
        send_frame(24'hFFFFFF, 24'hFFFFFF, 1, 1, 1, 1, 1, 3);
        send_frame(24'h8040C0, 24'h7F3F1E, 0, 1, 1, 0, 1, 1);
        // back to single after dual: B must fall silent
        send_frame(24'h0F0F0F, 24'hF0F0F0, 1, 0, 0, 1, 0, 0);
        for (int i = 0; i < 30; i++) begin
            send_frame(24'($urandom), 24'($urandom), 1'($urandom), 1'($urandom),
                       1'($urandom), 1'($urandom), 1'($urandom), i % 4);
        end
        @(negedge clk);
        bit_ce = 1'b0;
        repeat (5) @(negedge clk);
        check(q_exp_a.size() == 0, "R2 frames outstanding", 32'(q_exp_a.size()), 32'h0);
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule